// File: doc/BRIEF.md
# Reference Level Calibration Stepper

This block keeps a digital reference level word for an analog-to-digital converter and moves it in small steps, one step per comparison result. An external comparator reports for each sample whether the converted value came out high or low. A low result raises the level by a programmable upward step. A high result lowers it by a separately programmed downward step. The level is clamped at both ends of its range instead of wrapping, so a long run of one-sided results leaves it pinned at a rail.

Software sets up three byte-wide registers through a simple write port. The control register holds an enable bit and a window-select bit. When the window-select bit is clear, steps are taken only while the receiver is tracking a signal. When it is set, steps are taken whenever the receiver is enabled, so the level settles mostly on noise. Larger steps settle faster at the cost of a coarser final level.

Top module: `adc_ref_cal_stepper`

## Requirements
- R1: After a synchronous active-low reset the level output is 2048 (mid-scale of 12 bits), and all three registers read as zero, so calibration starts disabled.
- R2: While the enable bit (bit 0 of the control register at address 0) is 0, comparison strobes leave the level unchanged.
- R3: With updates allowed, a strobe (`cmp_valid`=1) with `cmp_high`=0 adds the unsigned byte at address 1 to the level in the next cycle. Each strobe cycle applies exactly one step, and cycles without a strobe change nothing.
- R4: With updates allowed, a strobe with `cmp_high`=1 subtracts 256 minus the byte at address 2 from the level in the next cycle. So 0xF0 subtracts 16, 0xFF subtracts 1 and 0x00 subtracts 256.
- R5: When the window bit (bit 1 of address 0) is 0, strobes update the level only while `rx_track` is 1, whatever the value of `rx_en`.
- R6: When the window bit is 1, strobes update the level only while `rx_en` is 1, whatever the value of `rx_track`.
- R7: An upward step that would pass 4095 leaves the level at 4095.
- R8: A downward step that would go below 0 leaves the level at 0.
- R9: A register write does not change the level. A strobe in the same cycle as a write uses the old register value, and later strobes use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 up step, 2 down step |
| cfg_wdata | input | 8 | Register write data |
| rx_en | input | 1 | Receiver enabled |
| rx_track | input | 1 | Receiver is tracking a signal |
| cmp_valid | input | 1 | One comparison result is present this cycle |
| cmp_high | input | 1 | Result: 1 = sample high, 0 = sample low |
| ref_level | output | 12 | Saturating reference level |

## Verification
The hardest case to reach from the ports is a write and a strobe landing in the same cycle, which is where old and new step values meet. The bench drives both on the same falling edge and checks that the step taken is the old one and the following step is the new one. The two rails are reached by running long one-sided strobe trains with the largest step magnitudes. A reference model in the bench clamps the expected level after every strobe.

// File: rtl/adc_ref_cal_pkg.sv
// Shared types for the reference calibration stepper.
// Assumes byte-wide registers and a 2-bit register address.
package adc_ref_cal_pkg;
    localparam int STEP_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_UP   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DN   = 2'd2;

    typedef enum logic {
        WIN_TRACK = 1'b0,
        WIN_RXEN  = 1'b1
    } win_e;

    typedef struct packed {
        logic              cal_en;
        win_e              win;
        logic [STEP_W-1:0] step_up;
        logic [STEP_W-1:0] step_dn;
    } cal_cfg_t;
endpackage

// File: rtl/adc_ref_cal_regs.sv
// Configuration registers: control (enable, window), up step, down step.
// Assumes one write per cycle; writes to unmapped addresses are dropped.
module adc_ref_cal_regs
    import adc_ref_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [STEP_W-1:0] cfg_wdata,
    output cal_cfg_t          cfg
);
    // Register file update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                ADDR_CTRL: begin
                    cfg.cal_en <= cfg_wdata[0];
                    cfg.win    <= win_e'(cfg_wdata[1]);
                end
                ADDR_UP:   cfg.step_up <= cfg_wdata;
                ADDR_DN:   cfg.step_dn <= cfg_wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/adc_ref_cal_gate.sv
// Decides whether the current comparison strobe may move the level.
// Assumes the strobe and the receive status are sampled in the same cycle.
module adc_ref_cal_gate
    import adc_ref_cal_pkg::*;
(
    input  cal_cfg_t cfg,
    input  logic     rx_en,
    input  logic     rx_track,
    input  logic     cmp_valid,
    output logic     upd
);
    logic win_open;

    // Select the update window, then qualify with enable and strobe.
    always_comb begin
        win_open = (cfg.win == WIN_RXEN) ? rx_en : rx_track;
        upd      = cfg.cal_en && win_open && cmp_valid;
    end
endmodule

// File: rtl/adc_ref_cal_accum.sv
// Saturating level accumulator. The down byte is the low byte of a 9-bit
// negative number, so the applied change is (byte - 256).
// Assumes LEVEL_W > STEP_W + 1 so one step never spans the range twice.
module adc_ref_cal_accum #(
    parameter int LEVEL_W = 12,
    parameter int STEP_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic               go_down,
    input  logic [STEP_W-1:0]  step_up,
    input  logic [STEP_W-1:0]  step_dn,
    output logic [LEVEL_W-1:0] level
);
    localparam int SUM_W = LEVEL_W + 2;
    localparam logic [LEVEL_W-1:0] MID = LEVEL_W'(1) << (LEVEL_W - 1);
    localparam logic [LEVEL_W-1:0] MAX = {LEVEL_W{1'b1}};

    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;
    logic [LEVEL_W-1:0]      nxt;

    // Form the signed step and clamp the sum to the level range.
    always_comb begin
        if (go_down)
            delta = $signed({{(SUM_W-STEP_W){1'b1}}, step_dn});
        else
            delta = $signed({{(SUM_W-STEP_W){1'b0}}, step_up});
        sum = $signed({2'b00, level}) + delta;
        if (sum < 0)
            nxt = '0;
        else if (sum > $signed({2'b00, MAX}))
            nxt = MAX;
        else
            nxt = sum[LEVEL_W-1:0];
    end

    // Level register, mid-scale after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= MID;
        else if (upd)
            level <= nxt;
    end
endmodule

// File: rtl/adc_ref_cal_stepper.sv
// Top of the reference calibration stepper: registers, update gate and
// saturating accumulator. Assumes the comparator strobes at most once a cycle.
module adc_ref_cal_stepper
    import adc_ref_cal_pkg::*;
#(
    parameter int LEVEL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic               rx_en,
    input  logic               rx_track,
    input  logic               cmp_valid,
    input  logic               cmp_high,
    output logic [LEVEL_W-1:0] ref_level
);
    cal_cfg_t cfg;
    logic     upd;

    adc_ref_cal_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    adc_ref_cal_gate u_gate (
        .cfg       (cfg),
        .rx_en     (rx_en),
        .rx_track  (rx_track),
        .cmp_valid (cmp_valid),
        .upd       (upd)
    );

    adc_ref_cal_accum #(
        .LEVEL_W (LEVEL_W),
        .STEP_W  (STEP_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .go_down (cmp_high),
        .step_up (cfg.step_up),
        .step_dn (cfg.step_dn),
        .level   (ref_level)
    );
endmodule

// File: rtl/adc_ref_cal_stepper_chk.sv
// Property checker for the stepper, bound to the top module.
// Assumes the default 12-bit level.
module adc_ref_cal_stepper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_en,
    input logic        rx_track,
    input logic        cmp_valid,
    input logic        cmp_high,
    input logic        cal_en,
    input logic        win,
    input logic [7:0]  step_up,
    input logic [11:0] ref_level
);
    assert_reset_mid_R1: assert property (@(posedge clk)
        !rst_n |=> ref_level == 12'd2048);

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> $stable(ref_level));

    assert_no_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(ref_level));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en && cmp_valid && !cmp_high && (win ? rx_en : rx_track)
         && ({1'b0, ref_level} + {5'd0, step_up} <= 13'd4095))
        |=> ref_level == $past(ref_level) + 12'($past(step_up)));

    assert_track_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !rx_track) |=> $stable(ref_level));

    assert_rxen_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !rx_en) |=> $stable(ref_level));

    assert_top_rail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_level == 12'hFFF && cmp_valid && !cmp_high) |=> ref_level == 12'hFFF);

    assert_bottom_rail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_level == 12'h000 && cmp_valid && cmp_high) |=> ref_level == 12'h000);
endmodule

bind adc_ref_cal_stepper adc_ref_cal_stepper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rx_track  (rx_track),
    .cmp_valid (cmp_valid),
    .cmp_high  (cmp_high),
    .cal_en    (cfg.cal_en),
    .win       (cfg.win),
    .step_up   (cfg.step_up),
    .ref_level (ref_level)
);

// File: tb/adc_ref_cal_stepper_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module adc_ref_cal_stepper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rx_en = 1'b0;
    logic        rx_track = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        cmp_high = 1'b0;
    logic [11:0] ref_level;

    int checks = 0;
    int failures = 0;
    int exp_lvl = 2048;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_ref_cal_stepper u_adc_ref_cal_stepper (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_en(rx_en), .rx_track(rx_track),
        .cmp_valid(cmp_valid), .cmp_high(cmp_high), .ref_level(ref_level)
    );

    task automatic check(string req, int expv);
        checks++;
        if (int'(ref_level) != expv) begin
            failures++;
            $display("FAIL %s level actual=%0d expected=%0d", req, ref_level, expv);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One strobe; the level is sampled at the next falling edge.
    task automatic strobe(logic hi);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_high = hi;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_lvl = 2048;
        check("R1", exp_lvl);
        rx_track = 1'b1;
        strobe(1'b0);
        check("R1", exp_lvl);  // enable clear after reset
    endtask

    task automatic t_disabled();
        wr(2'd1, 8'd16);
        wr(2'd0, 8'h00);
        rx_en = 1'b1; rx_track = 1'b1;
        strobe(1'b0);
        check("R2", exp_lvl);
        strobe(1'b1);
        check("R2", exp_lvl);
    endtask

    task automatic t_up();
        wr(2'd0, 8'h01);
        strobe(1'b0); exp_lvl += 16;
        check("R3", exp_lvl);
        strobe(1'b0); exp_lvl += 16;
        check("R3", exp_lvl);
        repeat (4) @(negedge clk);
        check("R3", exp_lvl);  // no strobe, no change
    endtask

    task automatic t_down();
        wr(2'd2, 8'hF0);
        strobe(1'b1); exp_lvl -= 16;
        check("R4", exp_lvl);
        wr(2'd2, 8'h00);
        strobe(1'b1); exp_lvl -= 256;
        check("R4", exp_lvl);
        wr(2'd2, 8'hFF);
        strobe(1'b1); exp_lvl -= 1;
        check("R4", exp_lvl);
    endtask

    task automatic t_window_track();
        wr(2'd0, 8'h01);
        rx_en = 1'b1; rx_track = 1'b0;
        strobe(1'b0);
        check("R5", exp_lvl);
        rx_en = 1'b0; rx_track = 1'b1;
        strobe(1'b0); exp_lvl += 16;
        check("R5", exp_lvl);
    endtask

    task automatic t_window_rxen();
        wr(2'd0, 8'h03);
        rx_en = 1'b1; rx_track = 1'b0;
        strobe(1'b0); exp_lvl += 16;
        check("R6", exp_lvl);
        rx_en = 1'b0; rx_track = 1'b1;
        strobe(1'b0);
        check("R6", exp_lvl);
        rx_en = 1'b1;
    endtask

    task automatic t_top_rail();
        wr(2'd1, 8'd255);
        for (int i = 0; i < 12; i++) begin
            strobe(1'b0);
            exp_lvl = (exp_lvl + 255 > 4095) ? 4095 : exp_lvl + 255;
            check("R7", exp_lvl);
        end
    endtask

    task automatic t_bottom_rail();
        wr(2'd2, 8'h00);
        for (int i = 0; i < 18; i++) begin
            strobe(1'b1);
            exp_lvl = (exp_lvl - 256 < 0) ? 0 : exp_lvl - 256;
            check("R8", exp_lvl);
        end
    endtask

    task automatic t_write_timing();
        wr(2'd1, 8'd10);
        check("R9", exp_lvl);  // write alone leaves level
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'd100;
        cmp_valid = 1'b1; cmp_high = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; cmp_valid = 1'b0;
        exp_lvl += 10;
        check("R9", exp_lvl);
        strobe(1'b0); exp_lvl += 100;
        check("R9", exp_lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled();
        t_up();
        t_down();
        t_window_track();
        t_window_rxen();
        t_top_rail();
        t_bottom_rail();
        t_write_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule